// File: doc/BRIEF.md
# Eight-bit Add/Subtract/Modulo-3 Arithmetic Unit

This block is a purely combinational arithmetic unit for two 8-bit operands, A and B, steered by a 4-bit function code. It adds, subtracts or reduces A modulo 3, and it can pass either operand through unchanged. Each arithmetic operation runs in either an unsigned or a two's-complement signed reading of the operands, and the top bit of the function code picks which.

Alongside the 8-bit result the unit drives a negative indication and an overflow flag, so that a downstream display path can print signed results with a minus sign. The unit has no registers. It is meant to sit between an operand-capture stage and a result register. Its outputs follow its inputs in the same cycle.

The modulo-3 path uses no divider. It splits A into 2-bit pairs and folds their residues together. A fixed correction then handles negative signed values, so the remainder is always 0, 1 or 2.

Top module: `alu8_core`

## Requirements
- R1: Code 4'b0000 drives A on the result and code 4'b0001 drives B. In both cases negative and overflow are 0.
- R2: Code 4'b0010 drives (A+B) mod 256 and sets overflow to the carry out of bit 7. Negative is 0.
- R3: Code 4'b0011 drives (A−B) mod 256 and sets overflow exactly when B is greater than A (a borrow). Negative is 0.
- R4: Code 4'b0100 drives A mod 3, with A read as unsigned, on result bits [1:0]; bits [7:2] are 0. Negative and overflow are 0.
- R5: Code 4'b1010 drives the low 8 bits of the two's-complement sum, and negative equals result bit 7. Overflow is 1 when A and B have the same sign and the result sign differs from A's sign.
- R6: Code 4'b1011 drives the low 8 bits of the two's-complement difference A−B, and negative equals result bit 7. Overflow is 1 when A and B have different signs and the result sign differs from A's sign.
- R7: Code 4'b1100 reads A as two's complement (−128..127) and drives its non-negative remainder modulo 3 (0, 1 or 2) on the result. For example, −1 gives 2 and −128 gives 1. Negative and overflow are 0.
- R8: Every other function code drives a result of 0, with negative and overflow both 0.
- R9: Under either modulo code the result never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| fn_code | input | 4 | Function code; bit 3 selects the signed reading |
| result | output | 8 | Operation result |
| negative | output | 1 | Result is negative under signed add or subtract |
| overflow | output | 1 | Carry, borrow or signed overflow of add or subtract |

## Verification
The block holds no state, so any fault in the decode, the shared adder or the residue chain shows at the ports in the same cycle as the stimulus that exposes it. A wrong carry-in or operand inversion in the adder shows up as a result off by one, or as a wrong borrow, at operand boundaries such as 255+1, 0−1 and −128−1. A wrong pair residue or a missing sign correction appears as a remainder that is off modulo 3. It is most visible for values with the top bit set under the signed modulo code. Unused codes are swept with all-ones operands, so any leak from the datapath onto the result is visible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned FN_W   = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS_A = 4'b0000,
        FN_PASS_B = 4'b0001,
        FN_UADD   = 4'b0010,
        FN_USUB   = 4'b0011,
        FN_UMOD   = 4'b0100,
        FN_SADD   = 4'b1010,
        FN_SSUB   = 4'b1011,
        FN_SMOD   = 4'b1100
    } fn_e;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'd0,
        SEL_A     = 3'd1,
        SEL_B     = 3'd2,
        SEL_ARITH = 3'd3,
        SEL_MOD   = 3'd4
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic is_signed;
        logic subtract;
    } ctl_t;

    typedef struct packed {
        logic carry;
        logic sign_ovf;
    } add_flags_t;

    // Residue of a 2-bit pair modulo 3
    function automatic logic [1:0] pair_residue(input logic [1:0] p);
        return (p == 2'd3) ? 2'd0 : p;
    endfunction

    // Sum of two residues modulo 3 (inputs in 0..2)
    function automatic logic [1:0] residue_add(input logic [1:0] x, input logic [1:0] y);
        logic [2:0] s;
        s = {1'b0, x} + {1'b0, y};
        return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
    endfunction

    function automatic ctl_t decode_fn(input logic [FN_W-1:0] fn);
        ctl_t c;
        c = '{sel: SEL_ZERO, is_signed: 1'b0, subtract: 1'b0};
        case (fn)
            FN_PASS_A: c.sel = SEL_A;
            FN_PASS_B: c.sel = SEL_B;
            FN_UADD:   c.sel = SEL_ARITH;
            FN_USUB:   begin c.sel = SEL_ARITH; c.subtract = 1'b1; end
            FN_UMOD:   c.sel = SEL_MOD;
            FN_SADD:   begin c.sel = SEL_ARITH; c.is_signed = 1'b1; end
            FN_SSUB:   begin c.sel = SEL_ARITH; c.is_signed = 1'b1; c.subtract = 1'b1; end
            FN_SMOD:   begin c.sel = SEL_MOD; c.is_signed = 1'b1; end
            default:   c.sel = SEL_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [FN_W-1:0] fn_code,
    output ctl_t            ctl
);

    always_comb begin
        ctl = decode_fn(fn_code);
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         subtract,
    input  logic         is_signed,
    output logic [W-1:0] sum,
    output logic         ovf
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   full;
    add_flags_t   flags;

    always_comb begin
        b_eff = subtract ? ~op_b : op_b;
        full  = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, subtract};
        sum   = full[W-1:0];
        flags.carry    = full[W];
        flags.sign_ovf = (op_a[MSB] == b_eff[MSB]) && (full[MSB] != op_a[MSB]);
        if (is_signed) begin
            ovf = flags.sign_ovf;
        end else begin
            // carry out for add, borrow (no carry) for subtract
            ovf = flags.carry ^ subtract;
        end
    end

endmodule

// File: rtl/alu8_mod3.sv
module alu8_mod3
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] op_a,
    input  logic         is_signed,
    output logic [1:0]   rem
);

    localparam int unsigned NPAIRS = (W + 1) / 2;
    localparam int unsigned PAD_W  = 2 * NPAIRS;
    // 2^W mod 3 is 1 for even W, 2 for odd W; a set sign bit subtracts it
    localparam logic [1:0]  SIGN_ADJ = ((W % 2) == 0) ? 2'd2 : 2'd1;

    logic [PAD_W-1:0] a_pad;
    logic [1:0]       acc [NPAIRS+1];

    assign a_pad  = PAD_W'(op_a);
    assign acc[0] = 2'd0;

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        assign acc[g+1] = residue_add(acc[g], pair_residue(a_pad[2*g+1 -: 2]));
    end

    always_comb begin
        if (is_signed && op_a[W-1]) begin
            rem = residue_add(acc[NPAIRS], SIGN_ADJ);
        end else begin
            rem = acc[NPAIRS];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    input  logic [FN_W-1:0] fn_code,
    output logic [W-1:0]    result,
    output logic            negative,
    output logic            overflow
);

    ctl_t         ctl;
    logic [W-1:0] arith_sum;
    logic         arith_ovf;
    logic [1:0]   mod_rem;

    alu8_decode u_decode (
        .fn_code (fn_code),
        .ctl     (ctl)
    );

    alu8_addsub #(.W(W)) u_addsub (
        .op_a      (a_in),
        .op_b      (b_in),
        .subtract  (ctl.subtract),
        .is_signed (ctl.is_signed),
        .sum       (arith_sum),
        .ovf       (arith_ovf)
    );

    alu8_mod3 #(.W(W)) u_mod3 (
        .op_a      (a_in),
        .is_signed (ctl.is_signed),
        .rem       (mod_rem)
    );

    always_comb begin
        result   = '0;
        negative = 1'b0;
        overflow = 1'b0;
        case (ctl.sel)
            SEL_A:     result = a_in;
            SEL_B:     result = b_in;
            SEL_ARITH: begin
                result   = arith_sum;
                overflow = arith_ovf;
                negative = ctl.is_signed & arith_sum[W-1];
            end
            SEL_MOD:   result = W'(mod_rem);
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input logic [W-1:0]    a_in,
    input logic [W-1:0]    b_in,
    input logic [FN_W-1:0] fn_code,
    input logic [W-1:0]    result,
    input logic            negative,
    input logic            overflow
);

    logic is_mod, is_pass, is_arith;

    always_comb begin
        is_mod   = (fn_code == FN_UMOD) || (fn_code == FN_SMOD);
        is_pass  = (fn_code == FN_PASS_A) || (fn_code == FN_PASS_B);
        is_arith = (fn_code == FN_UADD) || (fn_code == FN_USUB) ||
                   (fn_code == FN_SADD) || (fn_code == FN_SSUB);
    end

    always_comb begin
        if (is_mod) begin
            AST_MOD_RANGE: assert (result <= W'(2)); // R9
        end
        if (fn_code == FN_PASS_A) begin
            AST_PASS_A: assert (result == a_in && !overflow && !negative); // R1
        end
        if (fn_code == FN_PASS_B) begin
            AST_PASS_B: assert (result == b_in && !overflow && !negative); // R1
        end
        if (is_mod || is_pass) begin
            AST_NO_OVERFLOW: assert (!overflow); // R4
        end
        if (!is_mod && !is_pass && !is_arith) begin
            AST_UNUSED_QUIET: assert (result == '0 && !overflow && !negative); // R8
        end
        if (negative) begin
            AST_NEG_SIGNED_ONLY: assert (fn_code == FN_SADD || fn_code == FN_SSUB); // R5
        end
        if (fn_code == FN_USUB) begin
            AST_BORROW: assert (overflow == (b_in > a_in)); // R3
        end
    end

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .a_in     (a_in),
    .b_in     (b_in),
    .fn_code  (fn_code),
    .result   (result),
    .negative (negative),
    .overflow (overflow)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    typedef struct packed {
        logic [7:0] v;
        logic       n;
        logic       o;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic [3:0] fn_code = '0;
    logic [7:0] result;
    logic       negative;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .a_in     (a_in),
        .b_in     (b_in),
        .fn_code  (fn_code),
        .result   (result),
        .negative (negative),
        .overflow (overflow)
    );

    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'b0000, 4'b0001: return "R1";
            4'b0010: return "R2";
            4'b0011: return "R3";
            4'b0100: return "R4";
            4'b1010: return "R5";
            4'b1011: return "R6";
            4'b1100: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        int ua, ub, sa, sb, t;
        ua = int'(a);
        ub = int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        e = '0;
        case (f)
            4'b0000: e.v = a;
            4'b0001: e.v = b;
            4'b0010: begin t = ua + ub; e.v = t[7:0]; e.o = (t > 255); end
            4'b0011: begin t = ua - ub; e.v = t[7:0]; e.o = (ub > ua); end
            4'b0100: e.v = 8'(ua % 3);
            4'b1010: begin t = sa + sb; e.v = t[7:0]; e.n = t[7];
                           e.o = (t > 127) || (t < -128); end
            4'b1011: begin t = sa - sb; e.v = t[7:0]; e.n = t[7];
                           e.o = (t > 127) || (t < -128); end
            4'b1100: begin t = sa % 3; if (t < 0) t = t + 3; e.v = 8'(t); end
            default: e = '0;
        endcase
        return e;
    endfunction

    task automatic run_vec(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b,
                           input string tag);
        exp_t e;
        e = model(f, a, b);
        @(negedge clk);
        fn_code = f;
        a_in    = a;
        b_in    = b;
        #1;
        checks++;
        if (result !== e.v || negative !== e.n || overflow !== e.o) begin
            errors++;
            $display("FAIL %s %s fn=%b a=%02h b=%02h got res=%02h neg=%b ovf=%b exp res=%02h neg=%b ovf=%b",
                     req_of(f), tag, f, a, b, result, negative, overflow, e.v, e.n, e.o);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // idle state under reset: pass A of zero (R1)
        @(negedge clk);
        #1;
        checks++;
        if (result !== 8'h00 || negative !== 1'b0 || overflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got res=%02h neg=%b ovf=%b exp res=00 neg=0 ovf=0",
                     result, negative, overflow);
        end
        rst = 1'b0;

        // R1 pass-through
        run_vec(4'b0000, 8'hA5, 8'h3C, "R1 pass A");
        run_vec(4'b0001, 8'hA5, 8'hFF, "R1 pass B");
        // R2 unsigned add
        run_vec(4'b0010, 8'hFF, 8'h01, "R2 carry wrap");
        run_vec(4'b0010, 8'h7F, 8'h80, "R2 no carry");
        // R3 unsigned subtract
        run_vec(4'b0011, 8'h03, 8'h05, "R3 borrow");
        run_vec(4'b0011, 8'h05, 8'h05, "R3 equal");
        // R4 unsigned mod 3
        run_vec(4'b0100, 8'hFF, 8'h12, "R4 255");
        run_vec(4'b0100, 8'hFE, 8'h00, "R4 254");
        run_vec(4'b0100, 8'h00, 8'hFF, "R4 zero");
        // R5 signed add
        run_vec(4'b1010, 8'h7F, 8'h01, "R5 pos overflow");
        run_vec(4'b1010, 8'h80, 8'hFF, "R5 neg overflow");
        run_vec(4'b1010, 8'hFE, 8'h01, "R5 negative");
        // R6 signed subtract
        run_vec(4'b1011, 8'h80, 8'h01, "R6 overflow");
        run_vec(4'b1011, 8'h00, 8'h01, "R6 negative");
        run_vec(4'b1011, 8'h7F, 8'h80, "R6 pos overflow");
        // R7 signed mod 3, also R9 range
        run_vec(4'b1100, 8'hFF, 8'h00, "R7 minus one");
        run_vec(4'b1100, 8'h80, 8'h00, "R7 minus 128");
        run_vec(4'b1100, 8'h7F, 8'h00, "R7 plus 127");
        run_vec(4'b1100, 8'hFD, 8'h00, "R7 minus three");
        // R8 unused codes with all-ones operands
        for (int k = 0; k < 16; k++) begin
            if (!(k inside {0, 1, 2, 3, 4, 10, 11, 12}))
                run_vec(4'(k), 8'hFF, 8'hFF, "R8 unused");
        end
        // every A under both modulo codes (R4, R7, R9)
        for (int k = 0; k < 256; k++) begin
            run_vec(4'b0100, 8'(k), 8'h00, "R9 sweep unsigned");
            run_vec(4'b1100, 8'(k), 8'h00, "R9 sweep signed");
        end
        // constrained random over all codes
        for (int k = 0; k < 1500; k++) begin
            run_vec(4'($urandom_range(15)), 8'($urandom), 8'($urandom), "random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before all checks completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule